// File: doc/BRIEF.md
# Temperature Event Alarm Controller

This block watches a stream of signed temperature samples and drives an active-low event line. It holds three programmable limits: a window ceiling, a window floor and a critical trip point. It also holds a configuration word that sets the event mode, the hysteresis and whether the window limits take part. Each limit has its own hysteresis comparator. The event logic combines the comparator flags according to the mode. In interrupt mode the event latches and software clears it. In compare mode the event follows the flags. In critical-only mode the window limits are ignored.

While the critical condition is active, the event is held asserted in every mode and the software clear pulse is ignored. A single register write port loads the limits and the configuration. Temperatures and limits are 11-bit two's-complement numbers in quarter-degree steps, which covers the sensing span of -40 to 125 °C.

Top module: `temp_event_alarm`

## Requirements
- R1: While reset is active and after it, `event_n` is high. The reset values are: interrupt mode, hysteresis code 0, window enabled, ceiling 340 (85 °C), floor 0, critical 380 (95 °C).
- R2: A write with `wr_en` high loads `wr_data` into the register chosen by `wr_addr`. Address 0 is the configuration: bits [1:0] are the mode (0 interrupt, 1 compare, 2 or 3 critical-only), bits [3:2] are the hysteresis code, bit 4 is the window enable. Address 1 is the ceiling, address 2 the floor and address 3 the critical limit, each an 11-bit two's-complement value in units of 0.25 °C.
- R3: A temperature presented with `temp_vld` high is reflected on `event_n` at the clock edge that samples it. A change of `temp_in` while `temp_vld` is low has no effect on `event_n`.
- R4: In compare mode, the event is asserted while the ceiling condition, the floor condition (window enabled) or the critical condition is active. It drops by itself when all of them release. `sw_clear` has no effect.
- R5: With hysteresis H (code 0,1,2,3 = 0, 6, 12, 24 quarter-degrees), the ceiling and critical conditions set when the temperature is above the limit and release only when it is at or below limit - H. The floor condition sets when the temperature is below the floor and releases only when it is at or above floor + H.
- R6: In interrupt mode, the event latches when any enabled condition newly sets. It stays asserted after the temperature returns, until a `sw_clear` pulse.
- R7: While the critical condition is active, the event is asserted in every mode and `sw_clear` is ignored. In interrupt mode the event then stays latched until a clear that arrives after the critical condition has released.
- R8: In critical-only mode (code 2 or 3), only the critical condition drives the event. The window limits have no effect.
- R9: With the window enable bit at 0, ceiling and floor crossings do not assert the event in compare or interrupt mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_vld | input | 1 | New temperature sample present |
| temp_in | input | 11 | Signed temperature, 0.25 °C per step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 config, 1 ceiling, 2 floor, 3 critical) |
| wr_data | input | 11 | Register write value |
| sw_clear | input | 1 | Software clear pulse for the latched event |
| event_n | output | 1 | Active-low event output, idles high |

## Verification
The bench uses the package default of 11-bit words. It moves the limits to 25, -5 and 50 °C, so that a one-step ramp across the whole -40 to 125 °C span crosses each limit in both directions. The ramp is repeated for every combination of the four hysteresis codes, the three modes and the window enable bit. Clear pulses are scattered through the ramp, so they fall both inside and outside the critical lock. A bench-side arithmetic model gives the expected event level for every sample. Directed cases add the reset defaults, the alternate critical-only code, ignored temperature changes without a valid strobe, and a hysteresis band that is walked point by point.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;

    localparam int TEMP_W  = 11;
    localparam int ADDR_W  = 2;
    localparam int NUM_LIM = 3;
    localparam int LIM_UP  = 0;
    localparam int LIM_LO  = 1;
    localparam int LIM_CR  = 2;

    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef enum logic [1:0] {
        EVM_INTR     = 2'd0,
        EVM_CMP      = 2'd1,
        EVM_CRIT     = 2'd2,
        EVM_CRIT_ALT = 2'd3
    } ev_mode_e;

    // bit 4 window enable, bits 3:2 hysteresis code, bits 1:0 mode
    typedef struct packed {
        logic       win_en;
        logic [1:0] hyst_code;
        ev_mode_e   mode;
    } alarm_cfg_t;

    localparam int CFG_W = $bits(alarm_cfg_t);

    typedef struct packed {
        logic hi;
        logic lo;
        logic cr;
    } lim_flags_t;

    localparam temp_t RST_UPPER = 11'sd340;
    localparam temp_t RST_LOWER = 11'sd0;
    localparam temp_t RST_CRIT  = 11'sd380;
    localparam alarm_cfg_t RST_CFG = '{win_en: 1'b1, hyst_code: 2'd0, mode: EVM_INTR};

    // hysteresis in quarter degrees: 0, 6, 12, 24
    function automatic temp_t hyst_quarters(input logic [1:0] code);
        if (code == 2'd0) return '0;
        return temp_t'(3 << code);
    endfunction

    function automatic ev_mode_e norm_mode(input ev_mode_e m);
        return (m == EVM_CRIT_ALT) ? EVM_CRIT : m;
    endfunction

endpackage

// File: rtl/talm_regs.sv
module talm_regs
    import temp_alarm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  temp_t                    wr_data,
    output alarm_cfg_t               cfg_o,
    output temp_t [NUM_LIM-1:0]      lim_o
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_o <= RST_CFG;
        else if (wr_en && wr_addr == '0)
            cfg_o <= alarm_cfg_t'(wr_data[CFG_W-1:0]);
    end

    for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim
        localparam temp_t RST_VAL = (i == LIM_UP) ? RST_UPPER :
                                    (i == LIM_LO) ? RST_LOWER : RST_CRIT;
        always_ff @(posedge clk) begin
            if (rst)
                lim_o[i] <= RST_VAL;
            else if (wr_en && wr_addr == ADDR_W'(i + 1))
                lim_o[i] <= wr_data;
        end
    end

    // R2
    ceil_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1) |=> (lim_o[LIM_UP] == $past(wr_data)));

endmodule

// File: rtl/talm_limit_cmp.sv
module talm_limit_cmp
    import temp_alarm_pkg::*;
#(
    parameter bit LOW_SIDE = 1'b0
)(
    input  logic  clk,
    input  logic  rst,
    input  logic  sample_vld,
    input  temp_t temp,
    input  temp_t limit,
    input  temp_t hyst,
    output logic  flag_q,
    output logic  flag_nxt
);

    localparam int XW = TEMP_W + 1;

    logic signed [XW-1:0] t_x, l_x, h_x;
    logic trip, release_ok;

    always_comb begin
        t_x = {temp[TEMP_W-1], temp};
        l_x = {limit[TEMP_W-1], limit};
        h_x = {1'b0, hyst};
    end

    if (LOW_SIDE) begin : g_low
        always_comb begin
            trip       = t_x < l_x;
            release_ok = t_x >= (l_x + h_x);
        end
    end else begin : g_high
        always_comb begin
            trip       = t_x > l_x;
            release_ok = t_x <= (l_x - h_x);
        end
    end

    always_comb begin
        if (!sample_vld)
            flag_nxt = flag_q;
        else if (flag_q)
            flag_nxt = !release_ok;
        else
            flag_nxt = trip;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_nxt;
    end

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_vld |=> $stable(flag_q));

endmodule

// File: rtl/talm_event.sv
module talm_event
    import temp_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ev_mode_e   mode,
    input  logic       win_en,
    input  logic       sw_clear,
    input  lim_flags_t flg_q,
    input  lim_flags_t flg_nxt,
    output logic       event_q
);

    logic latch_q, latch_nxt, rise_any, ev_nxt;

    always_comb begin
        rise_any = (win_en & ((flg_nxt.hi & ~flg_q.hi) | (flg_nxt.lo & ~flg_q.lo)))
                 | (flg_nxt.cr & ~flg_q.cr);
        if (mode != EVM_INTR)
            latch_nxt = 1'b0;
        else
            latch_nxt = (latch_q & ~(sw_clear & ~flg_q.cr)) | rise_any;
        case (mode)
            EVM_INTR: ev_nxt = latch_nxt | flg_nxt.cr;
            EVM_CMP:  ev_nxt = (win_en & (flg_nxt.hi | flg_nxt.lo)) | flg_nxt.cr;
            default:  ev_nxt = flg_nxt.cr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            event_q <= 1'b0;
        end else begin
            latch_q <= latch_nxt;
            event_q <= ev_nxt;
        end
    end

    // R7
    crit_lock_chk: assert property (@(posedge clk) disable iff (rst)
        flg_q.cr |-> event_q);

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == EVM_INTR && sw_clear && !flg_q.cr && !rise_any) |=> !latch_q);

    // R4
    no_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != EVM_INTR) |=> !latch_q);

endmodule

// File: rtl/temp_event_alarm.sv
module temp_event_alarm
    import temp_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              temp_vld,
    input  logic [10:0]       temp_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [10:0]       wr_data,
    input  logic              sw_clear,
    output logic              event_n
);

    alarm_cfg_t          cfg;
    temp_t [NUM_LIM-1:0] lim;
    temp_t               hyst;
    logic [NUM_LIM-1:0]  fq, fn;
    lim_flags_t          flg_q, flg_nxt;
    logic                event_q;

    talm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (temp_t'(wr_data)),
        .cfg_o   (cfg),
        .lim_o   (lim)
    );

    always_comb hyst = hyst_quarters(cfg.hyst_code);

    for (genvar i = 0; i < NUM_LIM; i++) begin : g_cmp
        talm_limit_cmp #(.LOW_SIDE(i == LIM_LO)) u_cmp (
            .clk        (clk),
            .rst        (rst),
            .sample_vld (temp_vld),
            .temp       (temp_t'(temp_in)),
            .limit      (lim[i]),
            .hyst       (hyst),
            .flag_q     (fq[i]),
            .flag_nxt   (fn[i])
        );
    end

    always_comb begin
        flg_q   = '{hi: fq[LIM_UP], lo: fq[LIM_LO], cr: fq[LIM_CR]};
        flg_nxt = '{hi: fn[LIM_UP], lo: fn[LIM_LO], cr: fn[LIM_CR]};
    end

    talm_event u_event (
        .clk      (clk),
        .rst      (rst),
        .mode     (norm_mode(cfg.mode)),
        .win_en   (cfg.win_en),
        .sw_clear (sw_clear),
        .flg_q    (flg_q),
        .flg_nxt  (flg_nxt),
        .event_q  (event_q)
    );

    assign event_n = ~event_q;

endmodule

// File: tb/temp_event_alarm_tb.sv
module temp_event_alarm_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        temp_vld = 1'b0;
    logic [10:0] temp_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [10:0] wr_data = '0;
    logic        sw_clear = 1'b0;
    logic        event_n;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // model state
    int m_mode = 0, m_h = 0;
    bit m_win = 1;
    int m_up = 340, m_lo_lim = 0, m_cr_lim = 380;
    bit m_hi = 0, m_lo = 0, m_cr = 0, m_latch = 0;

    always #5 clk = ~clk;

    temp_event_alarm u_dut (
        .clk(clk), .rst(rst), .temp_vld(temp_vld), .temp_in(temp_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sw_clear(sw_clear), .event_n(event_n)
    );

    function automatic bit model_event();
        int md = (m_mode == 3) ? 2 : m_mode;
        if (md == 0) return m_latch | m_cr;
        if (md == 1) return (m_win & (m_hi | m_lo)) | m_cr;
        return m_cr;
    endfunction

    task automatic check(input string tag, input bit exp_ev);
        bit act = ~event_n;
        n_chk++;
        if (act !== exp_ev) begin
            n_err++;
            $display("FAIL %s: event=%0b expected %0b (mode %0d hyst %0d win %0b)",
                     tag, act, exp_ev, m_mode, m_h, m_win);
        end
    endtask

    task automatic send_temp(input int t, input string tag);
        bit nhi, nlo, ncr, rise;
        @(negedge clk);
        temp_in  = 11'(t);
        temp_vld = 1'b1;
        @(negedge clk);
        temp_vld = 1'b0;
        // R5 hysteresis model
        nhi = m_hi ? !(t <= m_up - m_h)     : (t > m_up);
        nlo = m_lo ? !(t >= m_lo_lim + m_h) : (t < m_lo_lim);
        ncr = m_cr ? !(t <= m_cr_lim - m_h) : (t > m_cr_lim);
        rise = (m_win & ((nhi & !m_hi) | (nlo & !m_lo))) | (ncr & !m_cr);
        m_hi = nhi; m_lo = nlo; m_cr = ncr;
        m_latch = (m_mode == 0) ? (m_latch | rise) : 1'b0;
        check(tag, model_event());
    endtask

    task automatic pulse_clear(input string tag);
        @(negedge clk);
        sw_clear = 1'b1;
        @(negedge clk);
        sw_clear = 1'b0;
        if (m_mode == 0 && !m_cr) m_latch = 1'b0;
        check(tag, model_event());
    endtask

    task automatic write_reg(input int addr, input int val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 2'(addr);
        wr_data = 11'(val);
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        case (addr)
            0: begin m_mode = val & 3; m_h = ((val >> 2) & 3) == 0 ? 0 : (3 << ((val >> 2) & 3));
                     m_win = (val >> 4) & 1; end
            1: m_up = val;
            2: m_lo_lim = val;
            default: m_cr_lim = val;
        endcase
        if (m_mode != 0) m_latch = 1'b0;
    endtask

    function automatic string mode_tag();
        if (!m_win && m_mode < 2) return "R9";
        if (m_mode == 0) return "R6";
        if (m_mode == 1) return "R4";
        return "R8";
    endfunction

    task automatic ramp(input int lo_t, input int hi_t);
        int k = 0;
        for (int t = lo_t; t <= hi_t; t++) begin
            send_temp(t, mode_tag());
            k++;
            if (k % 53 == 0) pulse_clear((m_cr) ? "R7" : mode_tag());
        end
        for (int t = hi_t; t >= lo_t; t--) begin
            send_temp(t, mode_tag());
            k++;
            if (k % 53 == 0) pulse_clear((m_cr) ? "R7" : mode_tag());
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 output idle during reset
        check("R1", 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 1'b0);
        // R1 defaults: interrupt mode, ceiling 340
        send_temp(340, "R1");
        send_temp(341, "R1");
        send_temp(0, "R6");
        pulse_clear("R6");

        // R2 reprogram limits: ceiling 25C, floor -5C, critical 50C
        write_reg(1, 100);
        write_reg(2, -20);
        write_reg(3, 200);

        // R3 temperature change without strobe is ignored
        write_reg(0, 32'h11);
        send_temp(50, "R3");
        @(negedge clk);
        temp_in = 11'(150);
        repeat (3) @(negedge clk);
        check("R3", 1'b0);
        send_temp(150, "R3");

        // R5 walk a 6 C band in compare mode
        write_reg(0, 32'h1D);
        send_temp(101, "R5");
        send_temp(80, "R5");
        send_temp(77, "R5");
        send_temp(76, "R5");
        send_temp(-21, "R5");
        send_temp(2, "R5");
        send_temp(4, "R5");
        send_temp(50, "R5");

        // R7 critical lock in interrupt mode
        write_reg(0, 32'h10);
        send_temp(250, "R7");
        pulse_clear("R7");
        send_temp(150, "R7");
        pulse_clear("R7");
        send_temp(50, "R7");

        // R8 alternate critical-only code
        write_reg(0, 32'h13);
        send_temp(150, "R8");
        send_temp(-100, "R8");
        send_temp(201, "R8");
        pulse_clear("R8");
        send_temp(50, "R8");

        // sweeps
        for (int w = 1; w >= 0; w--)
            for (int md = 0; md < 3; md++)
                for (int hc = 0; hc < 4; hc++) begin
                    write_reg(0, (w << 4) | (hc << 2) | md);
                    ramp(-160, 500);
                end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule